// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block turns a register-file access request into a physical location inside a banked data memory of four 128-byte banks. A request is either direct, where a 7-bit instruction operand gives the offset and two bank-select bits in the status byte give the bank, or indirect, where an 8-bit file-select pointer together with a separate high bank bit gives the whole 9-bit location. The decoder reports the resulting bank and in-bank offset and says whether the offset falls in the special function register area at the bottom of every bank or in general purpose RAM above it.

A short, configurable list of offsets names registers that appear in every bank. A request that lands on one of these offsets is redirected to a single physical copy in a fixed home bank, and the output says that this happened. The offset itself is kept.

Requests enter on a valid/ready port and results leave on a valid/ready port through one register stage. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The result then stays on the outputs with `out_valid` high until it is taken on an edge where `out_ready` is high. While a result is waiting and `out_ready` is low, `in_ready` is low, so no request is dropped and no result is overwritten. The source must hold a request and its fields steady until it is accepted.

Top module: `bdm_addr_decoder`

## Requirements
- R1: A direct request (`in_indirect` = 0) gives bank = `in_status[6:5]`, with bit 6 as the bank MSB, and offset = `in_operand`.
- R2: An indirect request (`in_indirect` = 1) gives bank = {`in_ind_bank`, `in_fsr[7]`} and offset = `in_fsr[6:0]`. `in_operand` and the status bank bits have no effect on it.
- R3: `out_is_sfr` is 1 exactly when the final offset is below SFR_LIMIT (default 20h). Offset 1Fh is an SFR and 20h is RAM.
- R4: If the final offset equals an entry of the mirror list (default 00h, 02h, 03h, 04h, 0Ah, 0Bh), the bank becomes MIRROR_BANK (default 0), the offset is kept and `out_mirror` = 1. Otherwise `out_mirror` = 0 and the bank is kept.
- R5: Status bits other than 6 and 5 have no effect on any output.
- R6: A request accepted on a rising edge appears on the outputs with `out_valid` = 1 right after that edge.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and all result outputs stay unchanged.
- R8: After reset, `out_valid` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Decoder can take a request |
| in_operand | input | 7 | Direct-access operand offset |
| in_status | input | 8 | Status byte; bits 6:5 select the bank |
| in_fsr | input | 8 | File-select pointer for indirect access |
| in_ind_bank | input | 1 | High bank bit for indirect access |
| in_indirect | input | 1 | 1 = indirect request, 0 = direct |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_bank | output | 2 | Physical bank |
| out_offset | output | 7 | Offset within the bank |
| out_is_sfr | output | 1 | 1 = special function register area, 0 = general RAM |
| out_mirror | output | 1 | 1 = offset redirected to the mirror home bank |

## Verification
Two functions can act on the same request. The first is indirect address formation and the second is the mirror redirect, which both decide the output bank. The bench sends indirect requests whose pointer and high bank bit point into bank 1 or 3 at a mirrored offset. It expects the home bank, the pointer's low seven bits as the offset, and the mirror flag set. A second overlap, between a stalled result and the next request already waiting at the input, is tested by holding `out_ready` low for several cycles. The bench then checks that the first result stays unchanged and that the second result follows it in the cycle after the release.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int OFS_W  = 7;
  localparam int BANK_W = 2;
  localparam int FSR_W  = OFS_W + 1;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;
    logic              is_sfr;
    logic              mirror;
  } bdm_loc_t;

  localparam int LOC_W = $bits(bdm_loc_t);
endpackage

// File: rtl/bdm_addr_form.sv
module bdm_addr_form
  import bdm_pkg::*;
#(
  parameter int RP_LSB = 5
) (
  input  logic [OFS_W-1:0]  operand_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [FSR_W-1:0]  fsr_i,
  input  logic              ind_bank_i,
  input  logic              indirect_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [BANK_W-1:0] direct_bank;
  logic [BANK_W-1:0] ptr_bank;

  assign direct_bank = status_i[RP_LSB +: BANK_W];
  assign ptr_bank    = {ind_bank_i, fsr_i[FSR_W-1]};

  always_comb begin
    if (indirect_i) begin
      bank_o = ptr_bank;
      ofs_o  = fsr_i[OFS_W-1:0];
    end else begin
      bank_o = direct_bank;
      ofs_o  = operand_i;
    end
  end
endmodule

// File: rtl/bdm_region_class.sv
module bdm_region_class
  import bdm_pkg::*;
#(
  parameter logic [OFS_W-1:0]            SFR_LIMIT   = 7'h20,
  parameter int                          NUM_MIRROR  = 6,
  parameter logic [NUM_MIRROR*OFS_W-1:0] MIRROR_LIST = {7'h0B, 7'h0A, 7'h04, 7'h03, 7'h02, 7'h00},
  parameter logic [BANK_W-1:0]           MIRROR_BANK = '0
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output bdm_loc_t          loc_o
);
  logic [NUM_MIRROR-1:0] hit;

  for (genvar g = 0; g < NUM_MIRROR; g++) begin : g_mirror
    assign hit[g] = (ofs_i == MIRROR_LIST[g*OFS_W +: OFS_W]);
  end

  always_comb begin
    loc_o.ofs    = ofs_i;
    loc_o.is_sfr = (ofs_i < SFR_LIMIT);
    loc_o.mirror = |hit;
    loc_o.bank   = (|hit) ? MIRROR_BANK : bank_i;
  end
endmodule

// File: rtl/bdm_out_reg.sv
module bdm_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

  assert_accept_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid && (m_data == $past(s_data)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));

  assert_stall_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);
endmodule

// File: rtl/bdm_addr_decoder.sv
module bdm_addr_decoder
  import bdm_pkg::*;
#(
  parameter int                          RP_LSB      = 5,
  parameter logic [OFS_W-1:0]            SFR_LIMIT   = 7'h20,
  parameter int                          NUM_MIRROR  = 6,
  parameter logic [NUM_MIRROR*OFS_W-1:0] MIRROR_LIST = {7'h0B, 7'h0A, 7'h04, 7'h03, 7'h02, 7'h00},
  parameter logic [BANK_W-1:0]           MIRROR_BANK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OFS_W-1:0]  in_operand,
  input  logic [STAT_W-1:0] in_status,
  input  logic [FSR_W-1:0]  in_fsr,
  input  logic              in_ind_bank,
  input  logic              in_indirect,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BANK_W-1:0] out_bank,
  output logic [OFS_W-1:0]  out_offset,
  output logic              out_is_sfr,
  output logic              out_mirror
);
  logic [BANK_W-1:0] raw_bank;
  logic [OFS_W-1:0]  raw_ofs;
  bdm_loc_t          loc_d;
  bdm_loc_t          loc_q;
  logic [LOC_W-1:0]  loc_q_bits;

  bdm_addr_form #(.RP_LSB(RP_LSB)) u_form (
    .operand_i  (in_operand),
    .status_i   (in_status),
    .fsr_i      (in_fsr),
    .ind_bank_i (in_ind_bank),
    .indirect_i (in_indirect),
    .bank_o     (raw_bank),
    .ofs_o      (raw_ofs)
  );

  bdm_region_class #(
    .SFR_LIMIT   (SFR_LIMIT),
    .NUM_MIRROR  (NUM_MIRROR),
    .MIRROR_LIST (MIRROR_LIST),
    .MIRROR_BANK (MIRROR_BANK)
  ) u_class (
    .bank_i (raw_bank),
    .ofs_i  (raw_ofs),
    .loc_o  (loc_d)
  );

  bdm_out_reg #(.DATA_W(LOC_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (loc_d),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (loc_q_bits)
  );

  assign loc_q      = bdm_loc_t'(loc_q_bits);
  assign out_bank   = loc_q.bank;
  assign out_offset = loc_q.ofs;
  assign out_is_sfr = loc_q.is_sfr;
  assign out_mirror = loc_q.mirror;

  assert_sfr_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_sfr |-> out_offset < SFR_LIMIT);

  assert_ram_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_sfr |-> out_offset >= SFR_LIMIT);

  assert_mirror_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mirror |-> out_bank == MIRROR_BANK);

  assert_indirect_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_indirect |=> out_offset == $past(in_fsr[OFS_W-1:0]));
endmodule

// File: tb/bdm_addr_decoder_tb.sv
module bdm_addr_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [6:0] in_operand = '0;
  logic [7:0] in_status = '0;
  logic [7:0] in_fsr = '0;
  logic       in_ind_bank = 1'b0;
  logic       in_indirect = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_bank;
  logic [6:0] out_offset;
  logic       out_is_sfr;
  logic       out_mirror;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bdm_addr_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_status(in_status), .in_fsr(in_fsr),
    .in_ind_bank(in_ind_bank), .in_indirect(in_indirect),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bank(out_bank), .out_offset(out_offset),
    .out_is_sfr(out_is_sfr), .out_mirror(out_mirror)
  );

  function automatic logic [10:0] model(input logic ind, input logic [6:0] op,
                                        input logic [7:0] st, input logic [7:0] fsr,
                                        input logic ib);
    logic [1:0] b;
    logic [6:0] o;
    logic m;
    if (ind) begin b = {ib, fsr[7]}; o = fsr[6:0]; end
    else     begin b = st[6:5];      o = op;       end
    m = (o == 7'h00) || (o == 7'h02) || (o == 7'h03) || (o == 7'h04) ||
        (o == 7'h0A) || (o == 7'h0B);
    if (m) b = 2'd0;
    return {b, o, (o < 7'h20), m};
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    logic [10:0] act;
    act = {out_bank, out_offset, out_is_sfr, out_mirror};
    n_chk++;
    if (!out_valid || act !== exp) begin
      n_bad++;
      $display("FAIL %s: valid=%0b got bank/ofs/sfr/mir=%h expected %h", req, out_valid, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic ind, input logic [6:0] op, input logic [7:0] st,
                       input logic [7:0] fsr, input logic ib);
    in_valid = 1'b1; in_indirect = ind; in_operand = op;
    in_status = st; in_fsr = fsr; in_ind_bank = ib;
  endtask

  task automatic send(input string req, input logic ind, input logic [6:0] op,
                      input logic [7:0] st, input logic [7:0] fsr, input logic ib);
    @(negedge clk);
    drive(ind, op, st, fsr, ib);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, model(ind, op, st, fsr, ib));
  endtask

  task automatic t_reset();
    check_bit("R8 out_valid", out_valid, 1'b0);
    check_bit("R8 in_ready", in_ready, 1'b1);
  endtask

  task automatic t_direct();
    send("R1 bank0 ram", 1'b0, 7'h45, 8'h00, 8'h00, 1'b0);
    send("R1 bank1", 1'b0, 7'h30, 8'h20, 8'hFF, 1'b1);
    send("R1 bank2", 1'b0, 7'h7F, 8'h40, 8'h00, 1'b0);
    send("R1 bank3 sfr", 1'b0, 7'h11, 8'h60, 8'h00, 1'b0);
    send("R5 other status bits", 1'b0, 7'h55, 8'hBF, 8'h12, 1'b1);
    send("R5 other status bits low", 1'b0, 7'h21, 8'h9F, 8'h00, 1'b0);
  endtask

  task automatic t_indirect();
    send("R2 ptr bank0", 1'b1, 7'h7F, 8'h60, 8'h2A, 1'b0);
    send("R2 ptr bank1", 1'b1, 7'h00, 8'h00, 8'hC5, 1'b0);
    send("R2 ptr bank2", 1'b1, 7'h33, 8'h20, 8'h70, 1'b1);
    send("R2 ptr bank3", 1'b1, 7'h01, 8'h40, 8'hFF, 1'b1);
  endtask

  task automatic t_boundary();
    send("R3 offset 1F sfr", 1'b0, 7'h1F, 8'h20, 8'h00, 1'b0);
    send("R3 offset 20 ram", 1'b0, 7'h20, 8'h20, 8'h00, 1'b0);
    send("R3 ptr 9F sfr", 1'b1, 7'h00, 8'h00, 8'h9F, 1'b1);
    send("R3 ptr A0 ram", 1'b1, 7'h00, 8'h00, 8'hA0, 1'b1);
  endtask

  task automatic t_mirror();
    send("R4 direct bank3 0A", 1'b0, 7'h0A, 8'h60, 8'h00, 1'b0);
    send("R4 direct bank2 00", 1'b0, 7'h00, 8'h40, 8'h00, 1'b0);
    send("R4 direct bank1 01 not listed", 1'b0, 7'h01, 8'h20, 8'h00, 1'b0);
    send("R4 direct bank1 04", 1'b0, 7'h04, 8'h20, 8'h00, 1'b0);
  endtask

  task automatic t_concurrent();
    send("R2 R4 ptr bank1 03", 1'b1, 7'h40, 8'h00, 8'h83, 1'b0);
    send("R2 R4 ptr bank3 0B", 1'b1, 7'h40, 8'h00, 8'h8B, 1'b1);
    send("R2 R4 ptr bank2 02", 1'b1, 7'h7F, 8'h60, 8'h02, 1'b1);
  endtask

  task automatic t_backpressure();
    logic [10:0] ea, eb;
    ea = model(1'b0, 7'h50, 8'h60, 8'h00, 1'b0);
    eb = model(1'b1, 7'h00, 8'h00, 8'hB1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 7'h50, 8'h60, 8'h00, 1'b0);
    @(negedge clk);
    check("R6 first result", ea);
    drive(1'b1, 7'h00, 8'h00, 8'hB1, 1'b0);
    check_bit("R7 in_ready low when stalled", in_ready, 1'b0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R7 result held", ea);
    check_bit("R7 in_ready still low", in_ready, 1'b0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 second result after release", eb);
    @(negedge clk);
    check_bit("R6 valid drops when idle", out_valid, 1'b0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_boundary();
    t_mirror();
    t_concurrent();
    t_backpressure();
    finish_run();
  end
endmodule